// File: doc/BRIEF.md
# Split-Operand Mixed-Style Multiplier

This block multiplies two unsigned 8-bit operands and returns their full 16-bit product. It splits each operand into an upper and a lower nibble and forms the four 4x4 nibble products. It shifts each product to its weight and sums the four terms. The low×low and high×high products use a carry-save array in which any row whose multiplier bit is zero is bypassed. A bypassed row leaves the running sum and carry vectors unchanged, which reduces switching. The two cross products have equal weight and lie on the same path into the final sum, so they use a two-level 3:2 compression tree, which has a shorter delay.

The final sum compresses the four shifted terms with two rows of carry-save adders and then resolves them in one carry-propagate adder. The product can be registered at the output, which is the default. The operand width is a parameter. All arithmetic is derived from the half width, so the structure can be extended, but only the 8-bit configuration is required.

Top module: `split_mult`

## Requirements
- R1: For every pair of operands, p equals the unsigned product a*b, with the 16-bit result in p[15:0].
- R2: With the registered output, p shows the product of the operands present at a rising clock edge from that edge on. Between edges, p holds its value.
- R3: While rst_n is low, p is 0 at every rising clock edge.
- R4: If either operand is 0, the product is 0.
- R5: If a is 2^k, p equals b shifted left by k bits.
- R6: The largest operands, 255 and 255, give 0xFE01. No carry out of bit 15 is lost.
- R7: When a[7:4] and b[7:4] are both zero, only the low×low nibble product contributes, and p[15:8] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | 8 | Multiplicand, unsigned |
| b | input | 8 | Multiplier, unsigned |
| p | output | 16 | Product, unsigned |

## Verification
All 65,536 operand pairs are applied back to back, one pair per clock, and each result is compared with the product computed in the bench. Some pairs have an operand of zero, which exercises the bypass rows that stay idle. Pairs with a power-of-two a show whether each nibble product is given the correct shift. Pairs with both upper nibbles zero isolate the low×low array from the cross terms, and 255×255 stresses every carry into the top bit. A further vector, with a check before and after the clock edge, confirms that p changes only at the edge. A reset asserted in the middle of the run confirms that p is cleared.

// File: rtl/split_mult.sv
module split_mult #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H  = W / 2;
  localparam int PW = 2 * H;
  localparam int FW = 2 * W;

  function automatic logic [PW-1:0] bypass_array(input logic [H-1:0] x, input logic [H-1:0] y);
    logic [PW-1:0] s, c, pp, ns, nc;
    s = '0;
    c = '0;
    for (int j = 0; j < H; j++) begin
      if (y[j]) begin
        pp = {{H{1'b0}}, x} << j;
        ns = s ^ c ^ pp;
        nc = ((s & c) | (s & pp) | (c & pp)) << 1;
        s  = ns;
        c  = nc;
      end
    end
    return s + c;
  endfunction

  function automatic logic [PW-1:0] tree_mul(input logic [H-1:0] x, input logic [H-1:0] y);
    logic [PW-1:0] rows [H];
    logic [PW-1:0] s, c, ns;
    for (int j = 0; j < H; j++)
      rows[j] = y[j] ? ({{H{1'b0}}, x} << j) : '0;
    s = rows[0];
    c = rows[1];
    for (int j = 2; j < H; j++) begin
      ns = s ^ c ^ rows[j];
      c  = ((s & c) | (s & rows[j]) | (c & rows[j])) << 1;
      s  = ns;
    end
    return s + c;
  endfunction

  logic [H-1:0]  a_hi, a_lo, b_hi, b_lo;
  logic [PW-1:0] pp_ll, pp_hh, pp_hl, pp_lh;
  logic [FW-1:0] t0, t1, t2, t3, s1, c1, s2, c2, sum;

  assign a_hi = a[W-1:H];
  assign a_lo = a[H-1:0];
  assign b_hi = b[W-1:H];
  assign b_lo = b[H-1:0];

  assign pp_ll = bypass_array(a_lo, b_lo);
  assign pp_hh = bypass_array(a_hi, b_hi);
  assign pp_hl = tree_mul(a_hi, b_lo);
  assign pp_lh = tree_mul(a_lo, b_hi);

  assign t0 = {{(FW-PW){1'b0}}, pp_ll};
  assign t1 = {{(FW-PW){1'b0}}, pp_hl} << H;
  assign t2 = {{(FW-PW){1'b0}}, pp_lh} << H;
  assign t3 = {{(FW-PW){1'b0}}, pp_hh} << W;

  assign s1  = t0 ^ t1 ^ t2;
  assign c1  = ((t0 & t1) | (t0 & t2) | (t1 & t2)) << 1;
  assign s2  = s1 ^ c1 ^ t3;
  assign c2  = ((s1 & c1) | (s1 & t3) | (c1 & t3)) << 1;
  assign sum = s2 + c2;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p <= '0;
        else        p <= sum;
      end
    end else begin : g_comb
      assign p = sum;
    end
  endgenerate
endmodule

// File: rtl/split_mult_chk.sv
module split_mult_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (REG_OUT) begin : g_chk
      p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (p == ({{W{1'b0}}, $past(a)} * {{W{1'b0}}, $past(b)})));

      p_reset_zero_r3: assert property (@(posedge clk)
        !rst_n |=> (p == '0));

      p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((a == '0) || (b == '0)) |=> (p == '0));

      p_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((a[W-1:H] == '0) && (b[W-1:H] == '0)) |=> (p[2*W-1:W] == '0));
    end
  endgenerate
endmodule

bind split_mult split_mult_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p)
);

// File: tb/split_mult_tb.sv
module split_mult_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] p;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  split_mult u_dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [7:0] x, input logic [7:0] y);
    if (x == 0 || y == 0)                 return "R4";
    if (x == 8'hFF && y == 8'hFF)         return "R6";
    if ($countones(x) == 1)               return "R5";
    if (x[7:4] == 0 && y[7:4] == 0)       return "R7";
    return "R1";
  endfunction

  initial begin
    logic [7:0] px, py;
    repeat (3) @(negedge clk);
    check("R3 reset", p, 16'h0000);
    rst_n = 1'b1;

    @(negedge clk);
    a = 8'd3; b = 8'd5;
    #1 check("R2 before edge", p, 16'h0000);
    @(negedge clk);
    check("R2 after edge", p, 16'd15);

    px = 0; py = 0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(tag_for(px, py), p, 16'(int'(px) * int'(py)));
        if (px == 8'hFF && py == 8'hFF) check("R6 max", p, 16'hFE01);
        if ($countones(px) == 1 && px[0] == 1'b0)
          check("R5 shift", p, {8'h00, py} << $clog2(int'(px)));
        if (px[7:4] == 0 && py[7:4] == 0) check("R7 high byte", {8'h00, p[15:8]}, 16'h0000);
      end
      px = i[15:8]; py = i[7:0];
      a = px; b = py;
    end
    @(negedge clk);
    check(tag_for(px, py), p, 16'(int'(px) * int'(py)));

    a = 8'hC3; b = 8'h7E;
    rst_n = 1'b0;
    @(negedge clk);
    check("R3 mid reset", p, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", p, 16'(int'(8'hC3) * int'(8'h7E)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule